// File: doc/BRIEF.md
# ALU Status Flag Generator

This block sits beside an integer datapath and produces both the result and the six arithmetic status bits for byte-wide and word-wide add, subtract, increment, decrement and bitwise operations. A single registered flag word holds the status bits in fixed positions next to three control bits (single-step trap, interrupt enable, string direction). Operations update only the status bits. The control bits change only through a direct load of the whole word.

The result is combinational from the operand inputs. The flag word is registered: it takes the new status bits on the rising clock edge at which `op_valid` is high, or the masked load value when `load_en` is high. A load takes priority over an operation in the same cycle. In byte mode only the low byte of each operand is used, and the upper result bits read zero.

Top module: `alu_flag_unit`

## Requirements
- R1: The flag word places carry at bit 0, parity at 2, half-carry at 4, zero at 6, sign at 7, trap at 8, interrupt enable at 9, direction at 10 and overflow at 11. All other bits read zero. The word is zero after reset.
- R2: Operation code 0 (add) gives (a + b + carry_in) modulo 2^W, where W is 16 when `wide` is high and 8 otherwise. CF is the carry out of bit W-1.
- R3: Operation code 1 (subtract) gives (a - b - carry_in) modulo 2^W. CF is 1 exactly when a borrow is needed, that is when a < b + carry_in as unsigned values.
- R4: For arithmetic operations, AF is the carry out of bit 3 (add, increment) or the borrow into bit 3 (subtract, decrement).
- R5: PF is 1 when bits 7..0 of the flag source hold an even number of ones, in both byte and word mode.
- R6: ZF is 1 when the flag source at the selected width is zero, and SF equals its bit W-1. In byte mode the upper operand bits are ignored and result bits 15..8 are zero.
- R7: OF is 1 when the true signed result of an add, subtract, increment or decrement lies outside the signed range of W bits.
- R8: Operation codes 2 (increment, a + 1) and 3 (decrement, a - 1) ignore b and carry_in and leave CF at its previous value.
- R9: Operation codes 4 (AND), 5 (OR) and 6 (XOR) return the bitwise result. Code 7 (test) returns a unchanged and takes its flags from a AND b. All four clear CF, AF and OF.
- R10: An operation never changes the trap, interrupt-enable or direction bits.
- R11: When `load_en` is high, the flag word takes `load_word` with the reserved bits forced to zero, even if `op_valid` is also high.
- R12: With neither `op_valid` nor `load_en` high, the flag word holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Updates the status bits at the next edge |
| op_code | input | 3 | Operation select, encoding as in R2, R3, R8 and R9 |
| wide | input | 1 | 1 = word width, 0 = byte width |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| carry_in | input | 1 | Carry or borrow input for add and subtract |
| load_en | input | 1 | Direct load of the flag word |
| load_word | input | 16 | Value for the direct load |
| result | output | 16 | Combinational operation result |
| flag_word | output | 16 | Registered flag word |

## Verification
A wrong carry, borrow or half-carry path inside the block shows up as a wrong result or a wrong status bit one edge after the operation that exercises it. The sweeps therefore cover every byte value of one operand against a spread of values for the other, and every operation at each width. A wrong control-bit path or a wrong enable priority stays hidden until the next operation or load. For that reason, every operation compares the whole flag word, including the loaded control bits, against a model that the bench keeps separately. An upper-byte leak in byte mode appears directly on `result` and on the zero and sign bits, because the bench puts non-zero values in the upper operand bits during the byte sweep.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_INC  = 3'd2,
      OP_DEC  = 3'd3,
      OP_AND  = 3'd4,
      OP_OR   = 3'd5,
      OP_XOR  = 3'd6,
      OP_TEST = 3'd7
   } alu_op_e;

   // bit positions inside the flag word; consumers decode these
   localparam int FB_CARRY  = 0;
   localparam int FB_PARITY = 2;
   localparam int FB_HALF   = 4;
   localparam int FB_ZERO   = 6;
   localparam int FB_SIGN   = 7;
   localparam int FB_TRAP   = 8;
   localparam int FB_IRQ_EN = 9;
   localparam int FB_DIR    = 10;
   localparam int FB_OVF    = 11;
   localparam int FB_TOP    = 11;

   typedef struct packed {
      logic cf;
      logic pf;
      logic af;
      logic zf;
      logic sf;
      logic of;
   } status_t;

endpackage

// File: rtl/alu_flag_arith.sv
module alu_flag_arith
   import alu_flag_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  alu_op_e           op,
   input  logic              wide,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              carry_in,
   output logic [DATA_W-1:0] sum,
   output logic              carry_msb,
   output logic              carry_nib,
   output logic              ovf
);

   localparam int PAD_W = DATA_W - NARROW_W;

   logic [DATA_W-1:0]   b_eff;
   logic                c_eff;
   logic [DATA_W:0]     full_sum;
   logic [NARROW_W:0]   narrow_sum;
   logic [4:0]          nib_sum;
   logic                sa, sb, sr;

   // subtraction and decrement fold into one adder via inverted operand
   always_comb begin
      case (op)
         OP_ADD:  begin b_eff = b;    c_eff = carry_in;  end
         OP_SUB:  begin b_eff = ~b;   c_eff = ~carry_in; end
         OP_INC:  begin b_eff = '0;   c_eff = 1'b1;      end
         OP_DEC:  begin b_eff = '1;   c_eff = 1'b0;      end
         default: begin b_eff = b;    c_eff = 1'b0;      end
      endcase
   end

   assign full_sum   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
   assign narrow_sum = {1'b0, a[NARROW_W-1:0]} + {1'b0, b_eff[NARROW_W-1:0]}
                     + {{NARROW_W{1'b0}}, c_eff};
   assign nib_sum    = {1'b0, a[3:0]} + {1'b0, b_eff[3:0]} + {4'b0000, c_eff};

   assign sum       = wide ? full_sum[DATA_W-1:0]
                           : {{PAD_W{1'b0}}, narrow_sum[NARROW_W-1:0]};
   assign carry_msb = wide ? full_sum[DATA_W] : narrow_sum[NARROW_W];
   assign carry_nib = nib_sum[4];

   assign sa  = wide ? a[DATA_W-1]        : a[NARROW_W-1];
   assign sb  = wide ? b_eff[DATA_W-1]    : b_eff[NARROW_W-1];
   assign sr  = wide ? full_sum[DATA_W-1] : narrow_sum[NARROW_W-1];
   assign ovf = (sa == sb) && (sr != sa);

endmodule

// File: rtl/alu_flag_logic.sv
module alu_flag_logic
   import alu_flag_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  alu_op_e           op,
   input  logic              wide,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic [DATA_W-1:0] src
);

   localparam int PAD_W = DATA_W - NARROW_W;

   logic [DATA_W-1:0] lane_mask;
   logic [DATA_W-1:0] raw_res, raw_src;

   assign lane_mask = wide ? {DATA_W{1'b1}} : {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};

   always_comb begin
      case (op)
         OP_AND:  begin raw_src = a & b; raw_res = a & b; end
         OP_OR:   begin raw_src = a | b; raw_res = a | b; end
         OP_XOR:  begin raw_src = a ^ b; raw_res = a ^ b; end
         OP_TEST: begin raw_src = a & b; raw_res = a;     end
         default: begin raw_src = '0;    raw_res = '0;    end
      endcase
   end

   assign res = raw_res & lane_mask;
   assign src = raw_src & lane_mask;

endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval
   import alu_flag_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  alu_op_e           op,
   input  logic              wide,
   input  logic [DATA_W-1:0] arith_sum,
   input  logic              carry_msb,
   input  logic              carry_nib,
   input  logic              arith_ovf,
   input  logic [DATA_W-1:0] logic_res,
   input  logic [DATA_W-1:0] logic_src,
   input  logic              cf_prev,
   output logic [DATA_W-1:0] result,
   output status_t           st
);

   logic              is_logic;
   logic [DATA_W-1:0] value;

   assign is_logic = op[2];
   assign value    = is_logic ? logic_src : arith_sum;
   assign result   = is_logic ? logic_res : arith_sum;

   always_comb begin
      st.zf = (value == '0);
      st.sf = wide ? value[DATA_W-1] : value[NARROW_W-1];
      st.pf = ~^value[7:0];
      st.of = is_logic ? 1'b0 : arith_ovf;
      case (op)
         OP_ADD:  begin st.cf = carry_msb;  st.af = carry_nib;  end
         OP_SUB:  begin st.cf = ~carry_msb; st.af = ~carry_nib; end
         OP_INC:  begin st.cf = cf_prev;    st.af = carry_nib;  end
         OP_DEC:  begin st.cf = cf_prev;    st.af = ~carry_nib; end
         default: begin st.cf = 1'b0;       st.af = 1'b0;       end
      endcase
   end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_flag_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int FLAG_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic              wide,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              carry_in,
   input  logic              load_en,
   input  logic [FLAG_W-1:0] load_word,
   output logic [DATA_W-1:0] result,
   output logic [FLAG_W-1:0] flag_word
);

   // elaboration-time parameter checks
   if (NARROW_W < 8) begin : g_chk_narrow
      $error("NARROW_W must cover the parity byte");
   end
   if (DATA_W <= NARROW_W) begin : g_chk_data
      $error("DATA_W must exceed NARROW_W");
   end
   if (FLAG_W <= FB_TOP) begin : g_chk_flag
      $error("FLAG_W too small for the flag layout");
   end

   alu_op_e           op;
   logic [DATA_W-1:0] arith_sum, logic_res, logic_src;
   logic              carry_msb, carry_nib, arith_ovf;
   status_t           st;
   logic [FLAG_W-1:0] next_word, def_mask;

   assign op = alu_op_e'(op_code);

   alu_flag_arith #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_arith (
      .op(op), .wide(wide), .a(a), .b(b), .carry_in(carry_in),
      .sum(arith_sum), .carry_msb(carry_msb), .carry_nib(carry_nib), .ovf(arith_ovf)
   );

   alu_flag_logic #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_logic (
      .op(op), .wide(wide), .a(a), .b(b), .res(logic_res), .src(logic_src)
   );

   alu_flag_eval #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_eval (
      .op(op), .wide(wide), .arith_sum(arith_sum), .carry_msb(carry_msb),
      .carry_nib(carry_nib), .arith_ovf(arith_ovf), .logic_res(logic_res),
      .logic_src(logic_src), .cf_prev(flag_word[FB_CARRY]),
      .result(result), .st(st)
   );

   // per-bit assembly of the next flag word and the load mask
   for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_bit
      if (gi == FB_CARRY) begin : g_cf
         assign next_word[gi] = st.cf;  assign def_mask[gi] = 1'b1;
      end else if (gi == FB_PARITY) begin : g_pf
         assign next_word[gi] = st.pf;  assign def_mask[gi] = 1'b1;
      end else if (gi == FB_HALF) begin : g_af
         assign next_word[gi] = st.af;  assign def_mask[gi] = 1'b1;
      end else if (gi == FB_ZERO) begin : g_zf
         assign next_word[gi] = st.zf;  assign def_mask[gi] = 1'b1;
      end else if (gi == FB_SIGN) begin : g_sf
         assign next_word[gi] = st.sf;  assign def_mask[gi] = 1'b1;
      end else if (gi == FB_OVF) begin : g_of
         assign next_word[gi] = st.of;  assign def_mask[gi] = 1'b1;
      end else if (gi == FB_TRAP || gi == FB_IRQ_EN || gi == FB_DIR) begin : g_ctl
         assign next_word[gi] = flag_word[gi];  assign def_mask[gi] = 1'b1;
      end else begin : g_rsv
         assign next_word[gi] = 1'b0;  assign def_mask[gi] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_word <= '0;
      else if (load_en)  flag_word <= load_word & def_mask;
      else if (op_valid) flag_word <= next_word;
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !load_en) |=> $stable(flag_word)); // R12

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> flag_word == ($past(load_word) & $past(def_mask))); // R11

   AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !load_en) |=> (flag_word[FB_TRAP] == $past(flag_word[FB_TRAP]))
         && (flag_word[FB_IRQ_EN] == $past(flag_word[FB_IRQ_EN]))
         && (flag_word[FB_DIR] == $past(flag_word[FB_DIR]))); // R10

   AST_STEP_KEEPS_CF: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !load_en && (op == OP_INC || op == OP_DEC))
         |=> flag_word[FB_CARRY] == $past(flag_word[FB_CARRY])); // R8

   AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !load_en && op_code[2])
         |=> !flag_word[FB_CARRY] && !flag_word[FB_OVF] && !flag_word[FB_HALF]); // R9

   AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !load_en) |=> !(flag_word[FB_ZERO] && flag_word[FB_SIGN])); // R6

endmodule

// File: tb/alu_flag_unit_bench.sv
module alu_flag_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = 3'd0;
   logic        wide = 1'b0;
   logic [15:0] a = '0, b = '0;
   logic        carry_in = 1'b0;
   logic        load_en = 1'b0;
   logic [15:0] load_word = '0;
   logic [15:0] result, flag_word;

   int checks = 0;
   int failures = 0;
   logic [15:0] exp_flags = '0;
   int unsigned seed = 32'h1234_5678;

   localparam logic [15:0] DEF_MASK = 16'h0FD5;
   localparam logic [15:0] CTRL_MASK = 16'h0700;

   always #2 clk = ~clk;

   alu_flag_unit u_alu_flag_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .wide(wide), .a(a), .b(b), .carry_in(carry_in), .load_en(load_en),
      .load_word(load_word), .result(result), .flag_word(flag_word)
   );

   function automatic int sx(input int v, input int w);
      return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
   endfunction

   function automatic int unsigned next_rand(input int unsigned s);
      int unsigned x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   // reference model written from the requirements
   task automatic model(input logic [2:0] op, input logic w, input logic [15:0] av,
                        input logic [15:0] bv, input logic c, input logic [15:0] fprev,
                        output logic [15:0] r, output logic [15:0] f);
      int wd = w ? 16 : 8;
      int m = (1 << wd) - 1;
      int half = 1 << (wd - 1);
      int ai = int'(av) & m;
      int bi = int'(bv) & m;
      int ci = int'(c);
      int res = 0, src = 0, tru = 0;
      int cf = 0, af = 0, of = 0, pf, zf, sf;
      case (op)
         3'd0: begin // R2 add
            res = ai + bi + ci; cf = (res >> wd) & 1;
            tru = sx(ai, wd) + sx(bi, wd) + ci;
            af = ((ai ^ bi ^ res) >> 4) & 1;
         end
         3'd1: begin // R3 subtract
            res = ai - bi - ci; cf = (ai < bi + ci) ? 1 : 0;
            tru = sx(ai, wd) - sx(bi, wd) - ci;
            af = ((ai ^ bi ^ res) >> 4) & 1;
         end
         3'd2: begin // R8 increment
            res = ai + 1; cf = int'(fprev[0]); tru = sx(ai, wd) + 1;
            af = ((ai ^ 1 ^ res) >> 4) & 1;
         end
         3'd3: begin // R8 decrement
            res = ai - 1; cf = int'(fprev[0]); tru = sx(ai, wd) - 1;
            af = ((ai ^ 1 ^ res) >> 4) & 1;
         end
         3'd4: begin src = ai & bi; res = src; end // R9
         3'd5: begin src = ai | bi; res = src; end
         3'd6: begin src = ai ^ bi; res = src; end
         default: begin src = ai & bi; res = ai; end
      endcase
      if (op < 3'd4) begin
         src = res & m;
         of = (tru > half - 1 || tru < -half) ? 1 : 0; // R7
      end
      zf = ((src & m) == 0) ? 1 : 0;           // R6
      sf = (src >> (wd - 1)) & 1;              // R6
      pf = ($countones(src & 255) % 2 == 0) ? 1 : 0; // R5
      r = 16'(res & m);
      f = fprev & CTRL_MASK;                   // R10
      f[0] = cf[0]; f[2] = pf[0]; f[4] = af[0];
      f[6] = zf[0]; f[7] = sf[0]; f[11] = of[0];
   endtask

   task automatic run_op(input logic [2:0] op, input logic w, input logic [15:0] av,
                         input logic [15:0] bv, input logic c);
      logic [15:0] er, ef;
      model(op, w, av, bv, c, exp_flags, er, ef);
      op_code = op; wide = w; a = av; b = bv; carry_in = c; op_valid = 1'b1;
      @(negedge clk);
      checks++;
      if (result !== er || flag_word !== ef) begin
         failures++;
         $display("FAIL %s (flags R4 R5 R6 R7 R10) op=%0d wide=%0b a=%h b=%h c=%0b: result=%h flags=%h expected result=%h flags=%h",
                  (op == 3'd0) ? "R2" : (op == 3'd1) ? "R3" : (op < 3'd4) ? "R8" : "R9",
                  op, w, av, bv, c, result, flag_word, er, ef);
      end
      exp_flags = ef;
      op_valid = 1'b0;
   endtask

   task automatic do_load(input logic [15:0] w, input logic with_op);
      load_word = w; load_en = 1'b1;
      op_valid = with_op; op_code = 3'd0; wide = 1'b1; a = 16'h1234; b = 16'h4321;
      @(negedge clk);
      load_en = 1'b0; op_valid = 1'b0;
      exp_flags = w & DEF_MASK;
      checks++;
      if (flag_word !== exp_flags) begin
         failures++;
         $display("FAIL R11 load=%h with_op=%0b: flags=%h expected %h", w, with_op, flag_word, exp_flags);
      end
   endtask

   task automatic idle_cycle();
      seed = next_rand(seed);
      op_valid = 1'b0; load_en = 1'b0;
      a = seed[15:0]; b = seed[31:16]; op_code = seed[2:0]; load_word = seed[31:16];
      @(negedge clk);
      checks++;
      if (flag_word !== exp_flags) begin
         failures++;
         $display("FAIL R12 idle: flags=%h expected %h", flag_word, exp_flags);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired: flags=%h expected completion", flag_word);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++; // R1 reset value
      if (flag_word !== 16'h0000) begin
         failures++;
         $display("FAIL R1 reset: flags=%h expected 0000", flag_word);
      end

      // R11 load with reserved bits forced to zero (R1 layout)
      do_load(16'hFFFF, 1'b0);
      for (int i = 0; i < 3; i++) idle_cycle(); // R12
      do_load(16'h0300, 1'b1);                  // R11 load beats op
      idle_cycle();

      // byte sweep with trap and direction set, upper operand bits non-zero
      do_load(16'h0500, 1'b0);
      for (int av = 0; av < 256; av++) begin
         for (int bi = 0; bi < 16; bi++) begin
            for (int op = 0; op < 8; op++) begin
               logic [15:0] ga = 16'((av ^ 8'h5A) << 8) | 16'(av);
               logic [15:0] gb = 16'((bi * 29 + 7) << 8) | 16'(bi * 17);
               run_op(3'(op), 1'b0, ga, gb, 1'((av ^ bi ^ op) & 1));
            end
         end
      end

      // R8 explicit: byte increment wraps, CF kept
      do_load(16'h0001, 1'b0);
      run_op(3'd2, 1'b0, 16'hAAFF, 16'h0000, 1'b0);
      run_op(3'd3, 1'b1, 16'h8000, 16'hFFFF, 1'b1);

      // word corners with interrupt enable set
      do_load(16'h0201, 1'b0);
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            for (int op = 0; op < 8; op++) begin
               for (int c = 0; c < 2; c++) begin
                  logic [15:0] cv [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                         16'hFFFF, 16'h00FF, 16'h0F0F, 16'h8001};
                  run_op(3'(op), 1'b1, cv[i], cv[j], 1'(c));
               end
            end
         end
      end

      // random word and byte operations
      do_load(16'h0700, 1'b0);
      for (int k = 0; k < 4000; k++) begin
         seed = next_rand(seed);
         run_op(seed[2:0], seed[3], seed[19:4], 16'(seed >> 16) ^ 16'(k), seed[31]);
      end
      idle_cycle();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule